// File: doc/BRIEF.md
# DRAM Pattern Test Controller

This block runs a go/no-go test on a one-bit-wide dynamic memory. It walks a logical address counter across every location of the selected device size. For each of four data patterns it runs a write pass and then a read-and-compare pass. The four patterns are constant one, constant zero, the parity of the address bits, and the complement of that parity. The address-dependent patterns expose address-decoder faults, such as aliased or shorted address lines, that the constant patterns cannot reveal.

A separate cycle-level sequencer produces the memory strobes and the row/column multiplexing. The two blocks talk through a request channel and a completion signal. The controller presents an address, a write flag and a data bit with `req_valid_o`. The sequencer accepts the request with `req_ready_i`. It later reports completion with `rsp_valid_i`, and for reads it returns the bit on `rsp_rdata_i`.

At the first mismatch the controller stops. It raises `fail_o` and holds the failing address and pattern number until the next start. A burn-in input makes the whole program repeat until an error occurs.

Top module: `dram_pattern_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `pass_o`, `fail_o` and `req_valid_o` are all low.
- R2: A `start_i` pulse while not busy raises `busy_o` on the next cycle and clears `pass_o` and `fail_o`. The first request is a write to address 0. A `start_i` pulse while busy has no effect on the request stream.
- R3: The program runs pattern 0 (all ones), then 1 (all zeros), then 2 (address parity), then 3 (inverse parity). Each pattern has a write pass followed by a read pass. Each pass visits addresses 0 up to the terminal count in ascending order. `req_we_o` is 1 for writes and 0 for reads.
- R4: The terminal count is selected by `size_sel_i`, which is latched at start: 0 gives 2^SMALL_LOG2-1, 1 gives 2^MID_LOG2-1, and 2 or 3 give 2^LARGE_LOG2-1. No address above the terminal count is ever requested.
- R5: `req_wdata_o` carries the pattern bit for the current address in both passes. The bit is 1 for pattern 0 and 0 for pattern 1. For pattern 2 it is the XOR of all address bits, and for pattern 3 it is the inverse of that XOR.
- R6: While `req_valid_o` is high and `req_ready_i` is low, the address, write flag and data stay stable. After an acceptance, no new request appears until `rsp_valid_i` has been seen.
- R7: A read whose returned bit differs from the pattern bit stops the test. The controller raises `fail_o` and drops `busy_o`. `fail_addr_o` holds the failing address and `fail_test_o` holds the pattern number (0..3). These outputs are held until the next start.
- R8: A program that completes all eight passes with no mismatch, while `burn_in_i` is low at its end, drops `busy_o` and raises `pass_o`. `pass_o` and `fail_o` are never high together.
- R9: If `burn_in_i` is high when the last read pass ends, the program restarts at pattern 0, address 0, without leaving the busy state. A mismatch during burn-in still stops the test as in R7.
- R10: A start after a pass or a fail clears the previous result and runs a fresh program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a test program |
| size_sel_i | input | 2 | Device size select, latched at start |
| burn_in_i | input | 1 | Repeat the program at its end |
| req_valid_o | output | 1 | Access request pending |
| req_ready_i | input | 1 | Sequencer accepts the request |
| req_addr_o | output | LARGE_LOG2 | Logical address of the request |
| req_we_o | output | 1 | 1 = write, 0 = read |
| req_wdata_o | output | 1 | Pattern bit for this address |
| rsp_valid_i | input | 1 | Access completed |
| rsp_rdata_i | input | 1 | Bit read back, valid with rsp_valid_i on reads |
| busy_o | output | 1 | Program running |
| pass_o | output | 1 | Last program completed without error |
| fail_o | output | 1 | Mismatch detected |
| fail_addr_o | output | LARGE_LOG2 | Address of the first mismatch |
| fail_test_o | output | 2 | Pattern number of the first mismatch |

## Verification
The bench builds the block with SMALL_LOG2=4, MID_LOG2=5 and LARGE_LOG2=6, so devices of 16, 32 and 64 locations stand in for the real sizes. At these sizes every size selection, full eight-pass programs and several consecutive burn-in programs fit in a short run. The small sizes also make it possible to place a stuck cell outside the small range and confirm it is never touched. A behavioural memory model with random accept and completion delays can inject a stuck cell or an ignored address bit. The bench checks that the stuck cell fails in a constant pattern and that the aliased address is caught only by the parity patterns.

// File: rtl/dram_pattern_pkg.sv
package dram_pattern_pkg;

  typedef enum logic [1:0] {
    PAT_ONES    = 2'd0,
    PAT_ZEROS   = 2'd1,
    PAT_PARITY  = 2'd2,
    PAT_NPARITY = 2'd3
  } pat_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_PASS,
    ST_FAIL
  } state_e;

endpackage

// File: rtl/dpc_addr_cnt.sv
module dpc_addr_cnt #(
  parameter int SMALL_LOG2 = 16,
  parameter int MID_LOG2   = 18,
  parameter int LARGE_LOG2 = 20,
  localparam int AW        = LARGE_LOG2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [1:0]    size_sel_i,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};
  localparam logic [AW-1:0] TERM_S   = ALL_ONES >> (AW - SMALL_LOG2);
  localparam logic [AW-1:0] TERM_M   = ALL_ONES >> (AW - MID_LOG2);
  localparam logic [AW-1:0] TERM_L   = ALL_ONES;

  logic [AW-1:0] addr_q, term_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_q <= TERM_S;
    end else if (load_i) begin
      unique case (size_sel_i)
        2'd0:    term_q <= TERM_S;
        2'd1:    term_q <= TERM_M;
        default: term_q <= TERM_L;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (clear_i) addr_q <= '0;
    else if (step_i)  addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == term_q);

endmodule

// File: rtl/dpc_pattern.sv
module dpc_pattern
  import dram_pattern_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic [AW-1:0] addr_i,
  input  pat_e          pat_i,
  output logic          bit_o
);

  logic [AW:0] par_chain;

  // Parity reduction written out as a chain so depth follows AW.
  assign par_chain[0] = 1'b0;
  for (genvar g = 0; g < AW; g++) begin : g_par
    assign par_chain[g+1] = par_chain[g] ^ addr_i[g];
  end

  always_comb begin
    unique case (pat_i)
      PAT_ONES:    bit_o = 1'b1;
      PAT_ZEROS:   bit_o = 1'b0;
      PAT_PARITY:  bit_o = par_chain[AW];
      default:     bit_o = ~par_chain[AW];
    endcase
  end

endmodule

// File: rtl/dpc_err_trap.sv
module dpc_err_trap
  import dram_pattern_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          check_i,
  input  logic          rdata_i,
  input  logic          exp_i,
  input  logic [AW-1:0] addr_i,
  input  pat_e          pat_i,
  output logic          mismatch_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [1:0]    fail_test_o
);

  logic          fail_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    test_q;

  assign mismatch_o = rdata_i ^ exp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      addr_q <= '0;
      test_q <= '0;
    end else if (clear_i) begin
      fail_q <= 1'b0;
      addr_q <= '0;
      test_q <= '0;
    end else if (check_i && mismatch_o && !fail_q) begin
      fail_q <= 1'b1;
      addr_q <= addr_i;
      test_q <= pat_i;
    end
  end

  assign fail_o      = fail_q;
  assign fail_addr_o = addr_q;
  assign fail_test_o = test_q;

endmodule

// File: rtl/dram_pattern_ctrl.sv
module dram_pattern_ctrl
  import dram_pattern_pkg::*;
#(
  parameter int SMALL_LOG2 = 16,
  parameter int MID_LOG2   = 18,
  parameter int LARGE_LOG2 = 20,
  localparam int AW        = LARGE_LOG2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    size_sel_i,
  input  logic          burn_in_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  output logic          req_we_o,
  output logic          req_wdata_o,
  input  logic          rsp_valid_i,
  input  logic          rsp_rdata_i,
  output logic          busy_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [1:0]    fail_test_o
);

  state_e        state_q, state_d;
  pat_e          pat_q, pat_d;
  logic          rd_q, rd_d;
  logic          cnt_load, cnt_clear, cnt_step;
  logic          trap_clear, trap_check;
  logic [AW-1:0] addr;
  logic          last, exp_bit, mismatch;

  dpc_addr_cnt #(
    .SMALL_LOG2 (SMALL_LOG2),
    .MID_LOG2   (MID_LOG2),
    .LARGE_LOG2 (LARGE_LOG2)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .size_sel_i (size_sel_i),
    .clear_i    (cnt_clear),
    .step_i     (cnt_step),
    .addr_o     (addr),
    .last_o     (last)
  );

  dpc_pattern #(.AW(AW)) u_pat (
    .addr_i (addr),
    .pat_i  (pat_q),
    .bit_o  (exp_bit)
  );

  dpc_err_trap #(.AW(AW)) u_trap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (trap_clear),
    .check_i     (trap_check),
    .rdata_i     (rsp_rdata_i),
    .exp_i       (exp_bit),
    .addr_i      (addr),
    .pat_i       (pat_q),
    .mismatch_o  (mismatch),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .fail_test_o (fail_test_o)
  );

  always_comb begin
    state_d    = state_q;
    pat_d      = pat_q;
    rd_d       = rd_q;
    cnt_load   = 1'b0;
    cnt_clear  = 1'b0;
    cnt_step   = 1'b0;
    trap_clear = 1'b0;
    trap_check = 1'b0;
    unique case (state_q)
      ST_ISSUE: begin
        if (req_ready_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid_i) begin
          trap_check = rd_q;
          if (rd_q && mismatch) begin
            state_d = ST_FAIL;
          end else begin
            state_d = ST_ISSUE;
            if (last) begin
              cnt_clear = 1'b1;
              if (!rd_q) begin
                rd_d = 1'b1;
              end else begin
                rd_d = 1'b0;
                if (pat_q == PAT_NPARITY) begin
                  pat_d = PAT_ONES;
                  // End of program: loop in burn-in, else report pass.
                  if (!burn_in_i) state_d = ST_PASS;
                end else begin
                  pat_d = pat_e'(pat_q + 2'd1);
                end
              end
            end else begin
              cnt_step = 1'b1;
            end
          end
        end
      end
      default: begin
        if (start_i) begin
          state_d    = ST_ISSUE;
          pat_d      = PAT_ONES;
          rd_d       = 1'b0;
          cnt_load   = 1'b1;
          cnt_clear  = 1'b1;
          trap_clear = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pat_q   <= PAT_ONES;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pat_q   <= pat_d;
      rd_q    <= rd_d;
    end
  end

  assign req_valid_o = (state_q == ST_ISSUE);
  assign req_addr_o  = addr;
  assign req_we_o    = ~rd_q;
  assign req_wdata_o = exp_bit;
  assign busy_o      = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
  assign pass_o      = (state_q == ST_PASS);

endmodule

// File: rtl/dram_pattern_ctrl_chk.sv
module dram_pattern_ctrl_chk #(
  parameter int AW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          req_valid_o,
  input logic          req_ready_i,
  input logic [AW-1:0] req_addr_o,
  input logic          req_we_o,
  input logic          req_wdata_o,
  input logic          busy_o,
  input logic          pass_o,
  input logic          fail_o,
  input logic [AW-1:0] fail_addr_o,
  input logic [1:0]    fail_test_o
);

  assert_idle_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> busy_o);

  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !pass_o && !fail_o));

  assert_first_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (req_addr_o == '0 && req_we_o));

  assert_req_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_we_o) && $stable(req_wdata_o)));

  assert_one_outstanding_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> !req_valid_o);

  assert_fail_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_i) |=>
      (fail_o && !busy_o && $stable(fail_addr_o) && $stable(fail_test_o)));

  assert_flags_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!pass_o && !fail_o && !(pass_o && fail_o)));

endmodule

bind dram_pattern_ctrl dram_pattern_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_we_o    (req_we_o),
  .req_wdata_o (req_wdata_o),
  .busy_o      (busy_o),
  .pass_o      (pass_o),
  .fail_o      (fail_o),
  .fail_addr_o (fail_addr_o),
  .fail_test_o (fail_test_o)
);

// File: tb/dram_pattern_ctrl_bench.sv
module dram_pattern_ctrl_bench;

  localparam int SL    = 4;
  localparam int ML    = 5;
  localparam int LL    = 6;
  localparam int AW    = LL;
  localparam int DEPTH = 1 << LL;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          we;
    logic          wd;
  } req_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    size_sel_i = 2'd0;
  logic          burn_in_i = 1'b0;
  logic          req_valid_o;
  logic          req_ready_i = 1'b0;
  logic [AW-1:0] req_addr_o;
  logic          req_we_o;
  logic          req_wdata_o;
  logic          rsp_valid_i = 1'b0;
  logic          rsp_rdata_i = 1'b0;
  logic          busy_o, pass_o, fail_o;
  logic [AW-1:0] fail_addr_o;
  logic [1:0]    fail_test_o;

  always #5 clk = ~clk;

  dram_pattern_ctrl #(.SMALL_LOG2(SL), .MID_LOG2(ML), .LARGE_LOG2(LL)) u_dram_pattern_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .size_sel_i(size_sel_i),
    .burn_in_i(burn_in_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .req_we_o(req_we_o), .req_wdata_o(req_wdata_o),
    .rsp_valid_i(rsp_valid_i), .rsp_rdata_i(rsp_rdata_i), .busy_o(busy_o),
    .pass_o(pass_o), .fail_o(fail_o), .fail_addr_o(fail_addr_o), .fail_test_o(fail_test_o)
  );

  int   n_chk = 0;
  int   n_fail = 0;
  req_t exp_q[$];
  int   acc_cnt = 0;

  // fault model
  bit stuck_en = 0;
  int stuck_addr = 0;
  bit stuck_val = 0;
  bit alias_en = 0;
  int alias_bit = 0;

  bit mem [DEPTH];
  bit ref_mem [DEPTH];

  bit exp_fail;
  int exp_faddr, exp_ftest;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pat_bit(int t, int a);
    logic [AW-1:0] av = a[AW-1:0];
    case (t)
      0: return 1'b1;
      1: return 1'b0;
      2: return ^av;
      default: return ~^av;
    endcase
  endfunction

  function automatic int phys(int a);
    return alias_en ? (a & ~(1 << alias_bit)) : a;
  endfunction

  function automatic bit fault_rd(bit v, int p);
    return (stuck_en && p == stuck_addr) ? stuck_val : v;
  endfunction

  // Driver: expected request stream from the requirements (R3, R4, R5, R7, R9)
  task automatic build_expect(int lg, int nprog);
    req_t r;
    exp_q.delete();
    exp_fail = 0; exp_faddr = 0; exp_ftest = 0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 0;
    for (int p = 0; p < nprog; p++)
      for (int t = 0; t < 4; t++)
        for (int rd = 0; rd < 2; rd++)
          for (int a = 0; a < (1 << lg); a++) begin
            r.addr = a[AW-1:0];
            r.we   = (rd == 0);
            r.wd   = pat_bit(t, a);
            exp_q.push_back(r);
            if (rd == 0) ref_mem[phys(a)] = r.wd;
            else if (fault_rd(ref_mem[phys(a)], phys(a)) != r.wd) begin
              exp_fail = 1; exp_faddr = a; exp_ftest = t;
              return;
            end
          end
  endtask

  // Memory model, responder and scoreboard monitor
  initial begin
    bit pending = 0;
    int wcnt = 0;
    bit prd = 0;
    req_t got, want;
    forever begin
      @(negedge clk);
      if (rsp_valid_i) rsp_valid_i = 1'b0;
      if (pending) begin
        check(!req_valid_o, "R6 no request while outstanding", req_valid_o, 0);
        if (wcnt == 0) begin
          rsp_valid_i = 1'b1;
          rsp_rdata_i = prd;
          pending = 0;
        end else wcnt--;
      end else begin
        req_ready_i = ($urandom % 4) != 0;
        if (req_valid_o && req_ready_i) begin
          got.addr = req_addr_o; got.we = req_we_o; got.wd = req_wdata_o;
          acc_cnt++;
          if (exp_q.size() == 0) begin
            check(0, "R3 unexpected request", got, 0);
          end else begin
            want = exp_q.pop_front();
            check(got == want, "R3 R4 R5 request order/data", got, want);
          end
          if (req_we_o) mem[phys(int'(req_addr_o))] = req_wdata_o;
          prd = fault_rd(mem[phys(int'(req_addr_o))], phys(int'(req_addr_o)));
          pending = 1;
          wcnt = $urandom % 3;
        end
      end
    end
  end

  task automatic wait_acc(int n);
    int g = 0;
    while (acc_cnt < n && busy_o && g < 20000) begin
      @(negedge clk); g++;
    end
  endtask

  task automatic wait_idle();
    int g = 0;
    do begin
      @(negedge clk); g++;
    end while (busy_o && g < 20000);
    check(!busy_o, "R8 program completes", busy_o, 0);
  endtask

  task automatic run_case(int sel, int lg, bit burn, int nprog, int drop_at, bit poke);
    build_expect(lg, nprog);
    acc_cnt = 0;
    @(negedge clk);
    size_sel_i = sel[1:0]; burn_in_i = burn; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && !pass_o && !fail_o, "R2 R10 start clears flags", {busy_o, pass_o, fail_o}, 3'b100);
    if (poke) begin
      wait_acc(10);
      start_i = 1'b1;            // R2: ignored while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    if (drop_at > 0) begin
      wait_acc(8 * (1 << lg) + 10);
      check(busy_o && !pass_o, "R9 burn-in keeps running", {busy_o, pass_o}, 2'b10);
      wait_acc(drop_at);
      burn_in_i = 1'b0;
    end
    wait_idle();
    check(exp_q.size() == 0, "R3 all requests issued", exp_q.size(), 0);
    check(pass_o == !exp_fail, "R8 pass flag", pass_o, !exp_fail);
    check(fail_o == exp_fail, "R7 fail flag", fail_o, exp_fail);
    if (exp_fail) begin
      check(int'(fail_addr_o) == exp_faddr, "R7 fail address", fail_addr_o, exp_faddr);
      check(int'(fail_test_o) == exp_ftest, "R7 fail pattern", fail_test_o, exp_ftest);
      repeat (5) @(negedge clk);
      check(fail_o && !busy_o && int'(fail_addr_o) == exp_faddr, "R7 fail held",
            {fail_o, busy_o}, 2'b10);
    end
    burn_in_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !pass_o && !fail_o && !req_valid_o, "R1 in reset",
          {busy_o, pass_o, fail_o, req_valid_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy_o && !pass_o && !fail_o && !req_valid_o, "R1 after reset",
          {busy_o, pass_o, fail_o, req_valid_o}, 0);

    run_case(0, SL, 0, 1, 0, 1);                       // R2 R3 R5: clean, small, start poke
    run_case(1, ML, 0, 1, 0, 0);                       // R4: mid size
    stuck_en = 1; stuck_addr = 37; stuck_val = 0;
    run_case(2, LL, 0, 1, 0, 0);                       // R7: stuck cell caught in pattern 0
    run_case(0, SL, 0, 1, 0, 0);                       // R4: cell 37 outside small range, R10
    stuck_en = 0; alias_en = 1; alias_bit = 2;
    run_case(3, LL, 0, 1, 0, 0);                       // R5 R7: alias caught by parity pattern
    alias_en = 0;
    run_case(0, SL, 0, 1, 0, 0);                       // R10: fresh pass after fail
    run_case(0, SL, 1, 3, 2 * 8 * (1 << SL) + 7, 0);   // R9: burn-in, three programs
    stuck_en = 1; stuck_addr = 3; stuck_val = 1;
    run_case(0, SL, 1, 3, 0, 0);                       // R9 R7: burn-in stops on error
    stuck_en = 0;

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule